// File: doc/BRIEF.md
# Interrupt Request Capture Latch

This block turns a set of raw interrupt input lines into a vector of pending requests for a downstream priority resolver. Each line is sampled once per clock. A per-line trigger-select register decides whether the line is level-sensitive, so that its pending bit simply mirrors the sampled input, or edge-sensitive, so that a low-to-high transition between two consecutive samples latches a request that stays set until it is acknowledged.

Software programs the trigger-select register through a write port and reads it back. A per-instance constant mask decides which of its bits can be set at all: an instance whose low lines must stay edge-triggered uses one mask, and a second instance uses another. The priority logic acknowledges a serviced line with a strobe and a line index. That acknowledge clears an edge-sensitive request and leaves a level-sensitive one alone. A software initialisation strobe clears all pending requests and the remembered input levels while keeping the trigger selection. Only the hardware reset clears the trigger selection.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pending` and `trig_rd_data` both become all zero after that edge, whatever the other inputs are.
- R2: For a level-sensitive line (trigger-select bit i = 1), `pending[i]` after a clock edge equals `irq_in[i]` as sampled at that edge, in both directions.
- R3: For an edge-sensitive line (trigger-select bit i = 0), `pending[i]` becomes 1 after the first edge where `irq_in[i]` is sampled high following a low sample, and stays 1 when the input later falls.
- R4: An edge-sensitive line that is held high after its request was acknowledged raises no new request until it has been sampled low and then high again.
- R5: `ack_valid` with `ack_index` = i clears `pending[i]` after the next clock edge when line i is edge-sensitive and shows no new rising sample at that edge; a level-sensitive pending bit is not cleared by an acknowledge.
- R6: When an acknowledge for an edge-sensitive line meets a new rising sample on the same line at the same edge, the new request wins and `pending[i]` stays 1.
- R7: `trig_wr_en` stores `trig_wr_data` ANDed with the parameter `TRIG_MASK`, and `trig_rd_data` returns it from the cycle after the write; bits outside the mask always read 0.
- R8: `soft_init` clears every pending bit and every remembered previous level after the edge, leaving the trigger-select register unchanged, so an edge-sensitive input still held high afterwards is seen as a new rising edge one cycle later.
- R9: An acknowledge affects only the line whose index it carries; the pending bits of all other lines are unaffected.
- R10: `soft_init` overrides input sampling and acknowledges in the same cycle: `pending` is all zero after that edge even if a line rises at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high hardware reset |
| irq_in | input | N_LINES | Raw interrupt lines, sampled every clock |
| soft_init | input | 1 | Software initialisation strobe: clears requests and remembered levels |
| trig_wr_en | input | 1 | Write strobe for the trigger-select register |
| trig_wr_data | input | N_LINES | Write data; bit i = 1 selects level-sensitive for line i |
| trig_rd_data | output | N_LINES | Current trigger-select register contents |
| ack_valid | input | 1 | Acknowledge strobe from the priority logic |
| ack_index | input | IDX_W | Index of the acknowledged line |
| pending | output | N_LINES | Registered pending-request vector |

## Verification
Every result of this block is due exactly one rising edge after the edge that samples its stimulus: a pending bit after the input sample, a clear after the acknowledge or initialisation strobe, and a read-back value after the write. The bench changes inputs only on the falling edge and reads both outputs on the following falling edge, so each comparison sees the state produced by precisely one rising edge. A behavioural model in the bench applies the same one-edge rule to its own state on each rising edge and is compared on every cycle, both during directed sequences that line up acknowledges, initialisation and new edges in the same cycle and during a random phase.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

endpackage

// File: rtl/irq_trig_sel_reg.sv
module irq_trig_sel_reg #(
  parameter int unsigned          N_LINES   = 8,
  parameter logic [N_LINES-1:0]   TRIG_MASK = 8'hF8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] sel_q
);

  // Only the hardware reset touches this register; software
  // initialisation leaves the trigger selection in place.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (wr_en) begin
      sel_q <= wr_data & TRIG_MASK;
    end
  end

endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               ack_valid,
  input  logic [IDX_W-1:0]   ack_index,
  output logic [N_LINES-1:0] ack_hit
);

  for (genvar g = 0; g < N_LINES; g++) begin : g_hit
    assign ack_hit[g] = ack_valid && (ack_index == IDX_W'(g));
  end

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_init,
  input  logic       line_in,
  input  trig_mode_e mode,
  input  logic       ack_hit,
  output logic       pend_q
);

  logic prev_q;
  logic rise;

  assign rise = line_in && !prev_q;

  always_ff @(posedge clk) begin
    if (rst || soft_init) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_in;
      if (mode == TRIG_LEVEL) begin
        pend_q <= line_in;
      end else if (rise) begin
        pend_q <= 1'b1;
      end else if (ack_hit) begin
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int unsigned          N_LINES   = 8,
  parameter logic [N_LINES-1:0]   TRIG_MASK = 8'hF8,
  localparam int unsigned         IDX_W     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               soft_init,
  input  logic               trig_wr_en,
  input  logic [N_LINES-1:0] trig_wr_data,
  output logic [N_LINES-1:0] trig_rd_data,
  input  logic               ack_valid,
  input  logic [IDX_W-1:0]   ack_index,
  output logic [N_LINES-1:0] pending
);

  logic [N_LINES-1:0] sel_q;
  logic [N_LINES-1:0] ack_hit;

  irq_trig_sel_reg #(
    .N_LINES   (N_LINES),
    .TRIG_MASK (TRIG_MASK)
  ) u_sel (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (trig_wr_en),
    .wr_data (trig_wr_data),
    .sel_q   (sel_q)
  );

  irq_ack_decode #(
    .N_LINES (N_LINES)
  ) u_ack (
    .ack_valid (ack_valid),
    .ack_index (ack_index),
    .ack_hit   (ack_hit)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .soft_init (soft_init),
      .line_in   (irq_in[g]),
      .mode      (trig_mode_e'(sel_q[g])),
      .ack_hit   (ack_hit[g]),
      .pend_q    (pending[g])
    );
  end

  assign trig_rd_data = sel_q;

endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int unsigned          N_LINES   = 8,
  parameter logic [N_LINES-1:0]   TRIG_MASK = 8'hF8,
  localparam int unsigned         IDX_W     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] irq_in,
  input logic               soft_init,
  input logic               trig_wr_en,
  input logic [N_LINES-1:0] trig_wr_data,
  input logic [N_LINES-1:0] trig_rd_data,
  input logic               ack_valid,
  input logic [IDX_W-1:0]   ack_index,
  input logic [N_LINES-1:0] pending
);

  // R1: the cycle after a reset edge shows a cleared state
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pending == '0 && trig_rd_data == '0));

  // R2: level-sensitive lines mirror the previous sample
  assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !soft_init |=> ((pending & $past(trig_rd_data)) == ($past(irq_in) & $past(trig_rd_data))));

  // R3: an edge request is not dropped without acknowledge or init
  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!soft_init && !ack_valid) |=>
      ((~$past(trig_rd_data) & $past(pending) & ~pending) == '0));

  // R5: acknowledge of an edge line with its input low clears it
  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !soft_init && !trig_rd_data[ack_index] && !irq_in[ack_index])
      |=> !pending[$past(ack_index)]);

  // R7: written value appears masked the next cycle
  assert_trig_write_R7: assert property (@(posedge clk) disable iff (rst)
    trig_wr_en |=> (trig_rd_data == ($past(trig_wr_data) & TRIG_MASK)));

  // R7: bits outside the mask never read back as 1
  assert_trig_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (trig_rd_data & ~TRIG_MASK) == '0);

  // R8: initialisation keeps the trigger selection
  assert_init_keeps_sel_R8: assert property (@(posedge clk) disable iff (rst)
    (soft_init && !trig_wr_en) |=> $stable(trig_rd_data));

  // R10: initialisation wins over sampling and acknowledge
  assert_init_clears_R10: assert property (@(posedge clk) disable iff (rst)
    soft_init |=> (pending == '0));

endmodule

bind irq_req_latch irq_req_latch_chk #(
  .N_LINES   (N_LINES),
  .TRIG_MASK (TRIG_MASK)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_in       (irq_in),
  .soft_init    (soft_init),
  .trig_wr_en   (trig_wr_en),
  .trig_wr_data (trig_wr_data),
  .trig_rd_data (trig_rd_data),
  .ack_valid    (ack_valid),
  .ack_index    (ack_index),
  .pending      (pending)
);

// File: tb/sim_irq_req_latch.sv
module sim_irq_req_latch;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MASK = 8'hF8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = 8'h00;
  logic       soft_init = 1'b0;
  logic       trig_wr_en = 1'b0;
  logic [7:0] trig_wr_data = 8'h00;
  logic [7:0] trig_rd_data;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_index = 3'd0;
  logic [7:0] pending;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_req_latch #(
    .N_LINES   (8),
    .TRIG_MASK (MASK)
  ) u0 (
    .clk          (clk),
    .rst          (rst),
    .irq_in       (irq_in),
    .soft_init    (soft_init),
    .trig_wr_en   (trig_wr_en),
    .trig_wr_data (trig_wr_data),
    .trig_rd_data (trig_rd_data),
    .ack_valid    (ack_valid),
    .ack_index    (ack_index),
    .pending      (pending)
  );

  // Behavioural reference: per-line integer state updated on each rising edge
  int  m_pend [8];
  int  m_last [8];
  int  m_lvl  [8];
  bit  model_live = 0;

  always @(posedge clk) begin
    int new_lvl [8];
    for (int i = 0; i < 8; i++) new_lvl[i] = m_lvl[i];
    if (rst) begin
      for (int i = 0; i < 8; i++) begin
        m_pend[i] = 0; m_last[i] = 0; new_lvl[i] = 0;
      end
    end else begin
      if (trig_wr_en)
        for (int i = 0; i < 8; i++) new_lvl[i] = trig_wr_data[i] & MASK[i];
      for (int i = 0; i < 8; i++) begin
        if (soft_init) begin
          m_pend[i] = 0;
          m_last[i] = 0;
        end else begin
          if (m_lvl[i] != 0) begin
            m_pend[i] = irq_in[i];
          end else begin
            if (ack_valid && int'(ack_index) == i) m_pend[i] = 0;
            if (irq_in[i] && m_last[i] == 0) m_pend[i] = 1;
          end
          m_last[i] = irq_in[i];
        end
      end
    end
    for (int i = 0; i < 8; i++) m_lvl[i] = new_lvl[i];
    model_live = 1;
  end

  function automatic logic [7:0] pack(input int v [8]);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (v[i] != 0);
    return r;
  endfunction

  always @(negedge clk) begin
    if (model_live && !finished) begin
      checks++;
      if (pending !== pack(m_pend)) begin
        errors++;
        $display("FAIL model pending (R3 R5 R6) actual=%h expected=%h t=%0t",
                 pending, pack(m_pend), $time);
      end
      checks++;
      if (trig_rd_data !== pack(m_lvl)) begin
        errors++;
        $display("FAIL model trigger select (R7) actual=%h expected=%h t=%0t",
                 trig_rd_data, pack(m_lvl), $time);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (R1) actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset dominates activity on every input
    irq_in = 8'hFF; trig_wr_en = 1'b1; trig_wr_data = 8'hFF;
    soft_init = 1'b0; ack_valid = 1'b0;
    tick(); tick();
    check("R1 pending after reset", pending, 8'h00);
    check("R1 trig after reset", trig_rd_data, 8'h00);
    rst = 1'b0; irq_in = 8'h00; trig_wr_en = 1'b0;
    tick();

    // R7: masked writes
    trig_wr_en = 1'b1; trig_wr_data = 8'hFF; tick();
    check("R7 write FF", trig_rd_data, 8'hF8);
    trig_wr_data = 8'h0F; tick();
    check("R7 write 0F", trig_rd_data, 8'h08);
    trig_wr_data = 8'hA8; tick();
    trig_wr_en = 1'b0;
    check("R7 write A8", trig_rd_data, 8'hA8);

    // R2: line 3 level-sensitive
    irq_in = 8'h08; tick();
    check("R2 level high", pending, 8'h08);
    irq_in = 8'h00; tick();
    check("R2 level low", pending, 8'h00);

    // R3: line 0 edge-sensitive
    irq_in = 8'h01; tick();
    check("R3 edge set", pending, 8'h01);
    irq_in = 8'h00; tick();
    check("R3 edge held after fall", pending, 8'h01);
    ack_valid = 1'b1; ack_index = 3'd0; tick();
    ack_valid = 1'b0;
    check("R5 ack clears edge", pending, 8'h00);

    // R4: held-high line needs a fresh rise
    irq_in = 8'h02; tick();
    check("R4 first rise", pending, 8'h02);
    ack_valid = 1'b1; ack_index = 3'd1; tick();
    ack_valid = 1'b0;
    check("R4 ack while high", pending, 8'h00);
    tick(); tick();
    check("R4 held high no request", pending, 8'h00);
    irq_in = 8'h00; tick();
    irq_in = 8'h02; tick();
    check("R4 new rise", pending, 8'h02);
    irq_in = 8'h00; ack_valid = 1'b1; ack_index = 3'd1; tick();
    ack_valid = 1'b0;

    // R5: acknowledge leaves a level line set (line 5)
    irq_in = 8'h20; tick();
    check("R5 level set", pending, 8'h20);
    ack_valid = 1'b1; ack_index = 3'd5; tick();
    ack_valid = 1'b0;
    check("R5 level ack ignored", pending, 8'h20);
    irq_in = 8'h00; tick();

    // R6: acknowledge meets new rise on line 4
    irq_in = 8'h10; tick();
    irq_in = 8'h00; tick();
    check("R6 pending before", pending, 8'h10);
    irq_in = 8'h10; ack_valid = 1'b1; ack_index = 3'd4; tick();
    ack_valid = 1'b0;
    check("R6 rise beats ack", pending, 8'h10);
    irq_in = 8'h00; ack_valid = 1'b1; ack_index = 3'd4; tick();
    ack_valid = 1'b0;

    // R9: acknowledge only touches its own line
    irq_in = 8'h41; tick();
    check("R9 two requests", pending, 8'h41);
    irq_in = 8'h00; ack_valid = 1'b1; ack_index = 3'd6; tick();
    check("R9 other line kept", pending, 8'h01);
    ack_index = 3'd0; tick();
    ack_valid = 1'b0;

    // R8: initialisation keeps trigger select, clears remembered level
    irq_in = 8'h04; tick();
    check("R8 edge before init", pending, 8'h04);
    soft_init = 1'b1; tick();
    soft_init = 1'b0;
    check("R8 init clears pending", pending, 8'h00);
    check("R8 init keeps trig", trig_rd_data, 8'hA8);
    tick();
    check("R8 held input re-seen", pending, 8'h04);

    // R10: initialisation beats a same-cycle rise and acknowledge
    irq_in = 8'h06; soft_init = 1'b1; ack_valid = 1'b1; ack_index = 3'd2; tick();
    soft_init = 1'b0; ack_valid = 1'b0;
    check("R10 init wins", pending, 8'h00);
    tick();
    check("R10 after init", pending, 8'h06);
    irq_in = 8'h00; tick();

    // Random phase, checked against the reference model every cycle
    for (int n = 0; n < 400; n++) begin
      irq_in       = 8'($urandom);
      ack_valid    = ($urandom % 3) == 0;
      ack_index    = 3'($urandom);
      soft_init    = ($urandom % 29) == 0;
      trig_wr_en   = ($urandom % 17) == 0;
      trig_wr_data = 8'($urandom);
      tick();
    end
    trig_wr_en = 1'b0; soft_init = 1'b0; ack_valid = 1'b0;
    tick();
    finish_run();
  end

endmodule